// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver with Overrun Lock

This block is a serial port controller that acts as clock master. It drives a serial clock derived from the system clock, shifts 8-bit frames out most significant bit first, and samples 8-bit frames on the same clock. Software reaches it through a small register bus with four registers: control, status, transmit data and receive data. It can run a transfer that only transmits, one that only receives, or one that does both at once.

The receive path holds one finished frame. Reading the receive register while receive is still enabled lets the next frame proceed. A frame that finishes while the previous one is still unread raises an overrun. The overrun stops every further transfer until software clears it. To finish receiving cleanly, software first turns receive off and then reads the last byte. That read does not start a new frame.

The controller is a four-state machine. ST_IDLE leaves on "go" to ST_LOW. "Go" means no overrun, and either transmit is on with data waiting, or receive is on, transmit is off and the receive register is empty. ST_LOW goes to ST_HIGH on a half-period tick while bits remain. ST_LOW goes to ST_GAP on the tick that samples the last bit. ST_HIGH goes back to ST_LOW on a tick. ST_GAP goes to ST_IDLE on a tick.

Top module: `sync_serial_xcvr`

## Requirements
- R1: After reset, status reads 0x02: receive-full (bit 0) is 0, transmit-empty (bit 1) is 1 and overrun (bit 2) is 0. The serial clock and the serial data output are both high.
- R2: Address map. Address 0 is control: bit 0 enables transmit, bit 1 enables receive, bits 4:2 select the divider. Address 1 is status, with flags in bits 0 to 2 as in R1. Address 2 is transmit data (write). Address 3 is receive data (read).
- R3: The serial clock is the system clock divided by 4<<sel, so each half period lasts 2<<sel cycles. The clock idles high. Data changes on the falling edge and is sampled on the rising edge. A frame is 8 bits, MSB first.
- R4: Writing the transmit register clears transmit-empty. The flag is set again when that data is loaded into the shifter.
- R5: With transmit and receive both enabled, writing transmit data starts a full-duplex frame. At the end of the frame the sampled byte is in the receive register and receive-full is set.
- R6: A transmit-only frame (receive disabled) leaves receive-full and the receive register unchanged.
- R7: With receive enabled and transmit disabled, frames run with the data output held at ones. The next frame starts only after receive-full has been cleared.
- R8: A bus read of the receive register clears receive-full.
- R9: Clearing receive-enable and then reading the receive register starts no frame.
- R10: A receiving frame that ends while receive-full is set sets overrun, drops the new byte and keeps the old one.
- R11: While overrun is set, no frame starts. Writing status with bit 2 at 0 clears overrun. Writing bit 2 at 1 leaves it set.
- R12: A receive-register read in the same cycle as a frame's final rising edge counts as consumed before that edge. It returns the old byte, the new byte is stored, receive-full stays 1 and no overrun occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effects on receive data) |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from address |
| sclk_o | output | 1 | Serial clock, idle high |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
Two functions can fall in the same cycle: the software read that clears receive-full, and the final rising edge that completes the next frame. The bench counts serial clock falls of a full-duplex frame started while receive-full is still set. It then places the receive-register read exactly one half period after the eighth fall, which is the clock edge of the last sample. The bench judges the outcome from the returned byte (old data), the status afterwards (receive-full 1, overrun 0) and the next read (new data). The divider sweep over all eight settings checks the measured low-phase length against 2<<sel. In the same sweep it checks the shifted-out and shifted-in bytes against bench-computed patterns.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH, ST_GAP} ssx_state_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_TXD  = 2'd2;
    localparam logic [1:0] A_RXD  = 2'd3;
endpackage

// File: rtl/ssx_halfcnt.sv
// Half-period timer: reloads on restart or on its own tick.
module ssx_halfcnt #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int CNT_W = 2 ** SEL_W;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] reload;

    // half period = 2 << sel cycles, so reload = (2 << sel) - 1
    assign reload = ~({CNT_W{1'b1}} << ({1'b0, sel} + 1'b1));
    assign tick   = (cnt == '0) && !restart;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (restart || tick)
            cnt <= reload;
        else
            cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/ssx_txshift.sv
module ssx_txshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] din,
    input  logic         shift,
    output logic         bit_o
);
    logic [W-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh <= '1;
        else if (load)
            sh <= din;
        else if (shift)
            sh <= {sh[W-2:0], 1'b1};
    end

    assign bit_o = sh[W-1];
endmodule

// File: rtl/ssx_rxshift.sv
// Holds the first W-1 sampled bits; the last bit is taken straight from the pin.
module ssx_rxshift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sample,
    input  logic         bit_i,
    output logic [W-2:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (sample)
            q <= {q[W-3:0], bit_i};
    end
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr #(
    parameter int DATA_W = 8,
    parameter int SEL_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i
);
    import ssx_pkg::*;

    localparam int BCNT_W = $clog2(DATA_W);
    localparam int PAD_W  = DATA_W - 2 - SEL_W;

    ssx_state_e st, st_nxt;

    logic              tx_en, rx_en;
    logic [SEL_W-1:0]  div_sel;
    logic [DATA_W-1:0] tx_buf, rx_buf;
    logic              tx_empty, rx_full, ovr, rx_act, sclk_q;
    logic [BCNT_W-1:0] bcnt;
    logic [DATA_W-2:0] rx_q;
    logic              tick, tx_bit;

    wire wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
    wire wr_stat  = bus_wr && (bus_addr == A_STAT);
    wire wr_txd   = bus_wr && (bus_addr == A_TXD);
    wire rd_rxd   = bus_rd && (bus_addr == A_RXD);

    wire start_tx = tx_en && !tx_empty;
    wire start_rx = rx_en && !tx_en && !rx_full;
    wire go       = !ovr && (start_tx || start_rx);
    wire last_bit = (bcnt == BCNT_W'(DATA_W - 1));
    wire load     = (st == ST_IDLE) && go;
    wire sample   = (st == ST_LOW)  && tick;
    wire shift    = (st == ST_HIGH) && tick;
    wire done     = sample && last_bit;
    wire [DATA_W-1:0] rx_word = {rx_q, miso_i};

    ssx_halfcnt #(.SEL_W(SEL_W)) u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (st == ST_IDLE),
        .sel     (div_sel),
        .tick    (tick)
    );

    ssx_txshift #(.W(DATA_W)) u_txsh (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .din   (start_tx ? tx_buf : {DATA_W{1'b1}}),
        .shift (shift),
        .bit_o (tx_bit)
    );

    ssx_rxshift #(.W(DATA_W)) u_rxsh (
        .clk    (clk),
        .rst_n  (rst_n),
        .sample (sample),
        .bit_i  (miso_i),
        .q      (rx_q)
    );

    // next state
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: if (go)   st_nxt = ST_LOW;
            ST_LOW:  if (tick) st_nxt = last_bit ? ST_GAP : ST_HIGH;
            ST_HIGH: if (tick) st_nxt = ST_LOW;
            ST_GAP:  if (tick) st_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // outputs, flags and registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q   <= 1'b1;
            bcnt     <= '0;
            rx_act   <= 1'b0;
            tx_en    <= 1'b0;
            rx_en    <= 1'b0;
            div_sel  <= '0;
            tx_buf   <= '0;
            tx_empty <= 1'b1;
            rx_buf   <= '0;
            rx_full  <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (load) begin
                sclk_q <= 1'b0;
                bcnt   <= '0;
                rx_act <= rx_en;
            end
            if (sample) begin
                sclk_q <= 1'b1;
                bcnt   <= bcnt + 1'b1;
            end
            if (shift)
                sclk_q <= 1'b0;

            if (wr_ctrl) begin
                tx_en   <= bus_wdata[0];
                rx_en   <= bus_wdata[1];
                div_sel <= bus_wdata[2 +: SEL_W];
            end

            if (wr_txd) begin
                tx_buf   <= bus_wdata;
                tx_empty <= 1'b0;
            end else if (load && start_tx) begin
                tx_empty <= 1'b1;
            end

            if (wr_stat && !bus_wdata[2])
                ovr <= 1'b0;

            if (done && rx_act) begin
                if (rx_full && !rd_rxd) begin
                    ovr <= 1'b1;
                end else begin
                    rx_buf  <= rx_word;
                    rx_full <= 1'b1;
                end
            end else if (rd_rxd) begin
                rx_full <= 1'b0;
            end
        end
    end

    assign sclk_o = sclk_q;
    assign mosi_o = ((st == ST_LOW) || (st == ST_HIGH)) ? tx_bit : 1'b1;

    always_comb begin
        unique case (bus_addr)
            A_CTRL:  bus_rdata = {{PAD_W{1'b0}}, div_sel, rx_en, tx_en};
            A_STAT:  bus_rdata = {{(DATA_W-3){1'b0}}, ovr, tx_empty, rx_full};
            A_TXD:   bus_rdata = tx_buf;
            default: bus_rdata = rx_buf;
        endcase
    end
endmodule

// File: rtl/ssx_chk.sv
module ssx_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [1:0]        bus_addr,
    input logic              wdata_b2,
    input logic              sclk_o,
    input logic              rx_full,
    input logic              tx_empty,
    input logic              ovr,
    input logic [DATA_W-1:0] rx_buf
);
    import ssx_pkg::*;

    AST_OVR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && sclk_o) |=> sclk_o);                                          // R11

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !(bus_wr && bus_addr == A_STAT && !wdata_b2)) |=> ovr);       // R11

    AST_RXFULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_full) |-> $past(bus_rd && bus_addr == A_RXD));               // R8

    AST_TXE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_TXD) |=> !tx_empty);                         // R4

    AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> $stable(rx_buf));                                      // R10
endmodule

bind sync_serial_xcvr ssx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .wdata_b2 (bus_wdata[2]),
    .sclk_o   (sclk_o),
    .rx_full  (rx_full),
    .tx_empty (tx_empty),
    .ovr      (ovr),
    .rx_buf   (rx_buf)
);

// File: tb/sync_serial_xcvr_tb.sv
`timescale 1ns/1ps
module sync_serial_xcvr_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       sclk_o, mosi_o;
    logic       miso = 1'b1;

    int checks = 0, fails = 0;
    int cyc = 0;
    int frames = 0, falls = 0, idx = 0;
    int fall_cyc = 0, last_low = 0;
    logic [7:0] cap = 8'd0, last_cap = 8'd0, sbyte = 8'd0, rv;
    logic prev_sclk = 1'b1, prev_mosi = 1'b1;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    sync_serial_xcvr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso)
    );

    // serial slave model, looks just after each edge
    always @(posedge clk) begin
        #1;
        cyc++;
        if (!prev_sclk && sclk_o) begin
            cap = {cap[6:0], prev_mosi};
            last_low = cyc - fall_cyc;
            idx++;
            if (idx == 8) begin
                last_cap = cap;
                frames++;
                idx = 0;
                falls = 0;
            end
        end
        if (prev_sclk && !sclk_o) begin
            falls++;
            fall_cyc = cyc;
            miso = sbyte[7 - idx];
        end
        prev_sclk = sclk_o;
        prev_mosi = mosi_o;
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    always @(posedge clk) begin
        if (!finished && cyc > 150000) begin
            checks++; fails++;
            $display("FAIL watchdog: act cyc=%0d exp done", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act %0h exp %0h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wait_frames(int n);
        int target = frames + n;
        while (frames < target) @(negedge clk);
    endtask

    initial begin
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd1, rv);
        chk("R1 status", rv, 8'h02);
        chk("R1 sclk idle", sclk_o, 1);
        chk("R1 mosi idle", mosi_o, 1);

        // R2 R3 R5 divider sweep, full duplex
        for (int s = 0; s < 8; s++) begin
            logic [7:0] t;
            t = 8'hC3 + 8'(s * 29);
            sbyte = 8'h5A ^ 8'(s * 37);
            wr(2'd0, 8'((s << 2) | 3));
            rd(2'd0, rv);
            chk("R2 ctrl readback", rv, (s << 2) | 3);
            wr(2'd2, t);
            wait_frames(1);
            chk("R3 mosi byte", last_cap, t);
            chk("R3 half period", last_low, 2 << s);
            rd(2'd1, rv);
            chk("R5 status full", rv, 8'h03);
            rd(2'd3, rv);
            chk("R5 rx byte", rv, sbyte);
            repeat (2 << s) @(negedge clk);
        end

        // R4 R6 transmit only
        wr(2'd0, 8'h00);
        wr(2'd2, 8'h77);
        rd(2'd1, rv);
        chk("R4 tx_empty cleared", rv, 8'h00);
        chk("R4 no frame while disabled", sclk_o, 1);
        wr(2'd0, 8'h01);
        wait_frames(1);
        chk("R6 tx byte", last_cap, 8'h77);
        rd(2'd1, rv);
        chk("R6 R4 status", rv, 8'h02);
        repeat (4) @(negedge clk);

        // R7 R8 receive only
        sbyte = 8'h96;
        wr(2'd0, 8'h02);
        wait_frames(1);
        chk("R7 idle-high data", last_cap, 8'hFF);
        rd(2'd1, rv);
        chk("R7 status", rv, 8'h03);
        f0 = frames;
        repeat (40) @(negedge clk);
        chk("R7 held while full", frames, f0);
        sbyte = 8'h3C;
        rd(2'd3, rv);
        chk("R8 rx byte", rv, 8'h96);
        wait_frames(1);
        chk("R7 resumed after read", frames, f0 + 1);

        // R9 clean end
        repeat (4) @(negedge clk);
        wr(2'd0, 8'h00);
        rd(2'd3, rv);
        chk("R9 last byte", rv, 8'h3C);
        f0 = frames;
        repeat (40) @(negedge clk);
        chk("R9 no new frame", frames, f0);
        rd(2'd1, rv);
        chk("R8 full cleared", rv, 8'h02);

        // R12 read meets last rising edge (sel 0, half period 2)
        wr(2'd0, 8'h03);
        sbyte = 8'hA1;
        wr(2'd2, 8'h11);
        wait_frames(1);
        repeat (4) @(negedge clk);
        sbyte = 8'hB2;
        wr(2'd2, 8'h22);
        while (falls != 8) @(negedge clk);
        repeat (1) @(negedge clk);
        bus_rd = 1'b1; bus_addr = 2'd3; #1 rv = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
        chk("R12 old byte read", rv, 8'hA1);
        rd(2'd1, rv);
        chk("R12 full, no overrun", rv, 8'h03);
        rd(2'd3, rv);
        chk("R12 new byte kept", rv, 8'hB2);
        repeat (4) @(negedge clk);

        // R10 R11 overrun
        sbyte = 8'h44;
        wr(2'd2, 8'h55);
        wait_frames(1);
        repeat (4) @(negedge clk);
        sbyte = 8'h66;
        wr(2'd2, 8'h57);
        wait_frames(1);
        repeat (4) @(negedge clk);
        rd(2'd1, rv);
        chk("R10 overrun set", rv, 8'h07);
        rd(2'd3, rv);
        chk("R10 old byte kept", rv, 8'h44);
        f0 = frames;
        wr(2'd2, 8'h99);
        repeat (40) @(negedge clk);
        chk("R11 frozen", frames, f0);
        wr(2'd1, 8'h04);
        rd(2'd1, rv);
        chk("R11 write 1 keeps", rv, 8'h04);
        wr(2'd1, 8'h00);
        wait_frames(1);
        chk("R11 resumed byte", last_cap, 8'h99);
        rd(2'd1, rv);
        chk("R11 cleared", rv, 8'h03);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule